// File: doc/BRIEF.md
# Receiver Idle Timeout Counter

This block watches the flow of received characters and reports when the line has gone quiet for longer than a programmed interval. Each time a character is moved into the receive holding register, the block restarts a down-counter. It does this in three steps: it halts for one timer tick, loads a 16-bit preset, and resumes on the tick after that. If the counter reaches zero before the next character arrives, a ready flag is raised. Software typically uses this flag to collect a short message that never filled the receive FIFO. The preset is built from a high byte and a low byte. A preset of zero stands for 65536 counts. The preset should be longer than one character time.

The counter advances only on a timer clock-enable pulse. A one-byte command port turns timeout mode on and off. The enable command clears the flag and parks the counter until the first character arrives. The disable command stops counting. While the mode is off, character strobes are ignored. A character that arrives after a timeout clears the flag at once, which also withdraws the interrupt. Because of this, an interrupt service routine that starts late can find no ready bit set. The interrupt output is the flag gated by a mask input.

Top module: `rxto_timer`

## Requirements
- R1: After a synchronous active-low reset, `rdy` and `irq` are 0 and timeout mode is off.
- R2: With timeout mode on, a preset N from 1 to 65535, and no further character or command, `rdy` rises on the clock edge of the (N+2)th `tick` that follows the edge that accepted the character. The first tick loads the preset, the second tick resumes counting, and each later tick counts down by one.
- R3: With the mode on, a `char_xfer` pulse clears `rdy` on the same edge and restarts the halt/load/resume sequence. A character that arrives before expiry therefore postpones the timeout.
- R4: A command write whose upper nibble is 0xA turns the mode on and clears `rdy`. The lower nibble has no effect. The counter then stays parked, and `rdy` stays 0 until a character arrives.
- R5: A command write whose upper nibble is 0xC turns the mode off and stops the counter. `rdy` keeps its current value.
- R6: While the mode is off, `char_xfer` pulses are ignored, so `rdy` cannot rise.
- R7: `irq` equals `rdy` AND `irq_mask` at all times. This is combinational, with no added delay.
- R8: A preset of 0x0000 counts 65536 ticks, so `rdy` rises on the 65538th tick after the character.
- R9: A command write with any upper nibble other than 0xA or 0xC has no effect.
- R10: Priority within one cycle, from highest to lowest: enable command, then disable command, then character, then tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable, one cycle per timer count |
| char_xfer | input | 1 | Pulse when a received character enters the holding register |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte; the upper nibble selects the action |
| preset_hi | input | 8 | Upper byte of the reload value |
| preset_lo | input | 8 | Lower byte of the reload value |
| irq_mask | input | 1 | Interrupt mask for the ready flag |
| rdy | output | 1 | Counter-ready flag: timeout expired |
| irq | output | 1 | Masked timeout interrupt |

## Verification
A wrong phase or count value inside the block shows up at the ports as a ready flag that rises on the wrong tick. It appears within the preset interval plus two ticks, or it is lost entirely when a retrigger was dropped. A stale flag that a character or an enable command should have cleared becomes visible on the very next clock. A reference model in the bench is compared with `rdy` and `irq` on every cycle, so any such error is caught in the cycle where it first appears.

// File: rtl/rxto_pkg.sv
// Shared types and constants for the receiver idle timeout counter.
// Assumes commands are decoded on the upper nibble of the command byte.
package rxto_pkg;
    localparam logic [3:0] NIB_ENABLE  = 4'hA;
    localparam logic [3:0] NIB_DISABLE = 4'hC;

    typedef enum logic [1:0] {
        PH_PARK = 2'd0,   // stopped, waiting for a character
        PH_HALT = 2'd1,   // character seen, next tick reloads
        PH_LOAD = 2'd2,   // preset loaded, next tick resumes
        PH_RUN  = 2'd3    // counting down on each tick
    } phase_t;
endpackage

// File: rtl/rxto_cmd_dec.sv
// Command decoder: turns a command byte write into single-cycle enable
// and disable pulses. Assumes cmd_wr is a one-cycle strobe.
module rxto_cmd_dec
    import rxto_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_byte,
    output logic             en_cmd,
    output logic             dis_cmd
);
    localparam int NIB_LSB = CMD_W - 4;

    // Match the upper nibble against the two mode commands.
    always_comb begin
        en_cmd  = cmd_wr && (cmd_byte[CMD_W-1:NIB_LSB] == NIB_ENABLE);
        dis_cmd = cmd_wr && (cmd_byte[CMD_W-1:NIB_LSB] == NIB_DISABLE);
    end
endmodule

// File: rtl/rxto_count.sv
// Down-counter datapath: loads the preset (zero meaning the full range)
// and decrements on request. Assumes load and dec are never both high.
module rxto_count #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] preset_hi,
    input  logic [BYTE_W-1:0] preset_lo,
    input  logic              load,
    input  logic              dec,
    output logic              at_one
);
    localparam int PRE_W = 2 * BYTE_W;
    localparam int CNT_W = PRE_W + 1;

    logic [PRE_W-1:0] preset;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] count_q;

    // Extend the preset; an all-zero preset selects the full range.
    always_comb begin
        preset     = {preset_hi, preset_lo};
        reload_val = (preset == '0) ? {1'b1, {PRE_W{1'b0}}} : {1'b0, preset};
    end

    // Hold, load or decrement the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= reload_val;
        end else if (dec) begin
            count_q <= count_q - 1'b1;
        end
    end

    // Flag the final count so the sequencer can raise ready on this tick.
    always_comb begin
        at_one = (count_q == {{(CNT_W-1){1'b0}}, 1'b1});
    end

    p_load_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count_q != '0));
    p_dec_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (count_q != '0));
endmodule

// File: rtl/rxto_seq.sv
// Phase sequencer: owns the mode bit, the halt/load/resume phases and the
// ready flag. Assumes a priority of enable, disable, character, tick.
module rxto_seq
    import rxto_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic char_xfer,
    input  logic en_cmd,
    input  logic dis_cmd,
    input  logic at_one,
    output logic load,
    output logic dec,
    output logic rdy
);
    logic   mode_q;
    phase_t phase_q;
    logic   ready_q;
    logic   retrig;
    logic   tick_ok;

    // Work out which event owns this cycle.
    always_comb begin
        retrig  = char_xfer && mode_q && !en_cmd && !dis_cmd;
        tick_ok = tick && !en_cmd && !dis_cmd && !retrig;
        load    = tick_ok && (phase_q == PH_HALT);
        dec     = tick_ok && (phase_q == PH_RUN);
    end

    // Advance the mode, the phase and the ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            phase_q <= PH_PARK;
            ready_q <= 1'b0;
        end else if (en_cmd) begin
            mode_q  <= 1'b1;
            phase_q <= PH_PARK;
            ready_q <= 1'b0;
        end else if (dis_cmd) begin
            mode_q  <= 1'b0;
            phase_q <= PH_PARK;
        end else if (retrig) begin
            phase_q <= PH_HALT;
            ready_q <= 1'b0;
        end else if (tick_ok) begin
            case (phase_q)
                PH_HALT: phase_q <= PH_LOAD;
                PH_LOAD: phase_q <= PH_RUN;
                PH_RUN: begin
                    if (at_one) begin
                        phase_q <= PH_PARK;
                        ready_q <= 1'b1;
                    end
                end
                default: phase_q <= PH_PARK;
            endcase
        end
    end

    assign rdy = ready_q;

    p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> $past(tick));
    p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_q) |-> ($past(en_cmd) || $past(char_xfer)));
    p_enable_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en_cmd |=> (!ready_q && phase_q == PH_PARK));
    p_off_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> (phase_q == PH_PARK));
    p_disable_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_cmd && !en_cmd) |=> $stable(ready_q));
endmodule

// File: rtl/rxto_timer.sv
// Top of the receiver idle timeout counter: decodes commands, sequences
// the reload on each character and gates the ready flag into an interrupt.
// Assumes all inputs are synchronous to clk.
module rxto_timer #(
    parameter int BYTE_W = 8,
    parameter int CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              char_xfer,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_byte,
    input  logic [BYTE_W-1:0] preset_hi,
    input  logic [BYTE_W-1:0] preset_lo,
    input  logic              irq_mask,
    output logic              rdy,
    output logic              irq
);
    logic en_cmd;
    logic dis_cmd;
    logic load;
    logic dec;
    logic at_one;

    rxto_cmd_dec #(.CMD_W(CMD_W)) u_dec (
        .cmd_wr   (cmd_wr),
        .cmd_byte (cmd_byte),
        .en_cmd   (en_cmd),
        .dis_cmd  (dis_cmd)
    );

    rxto_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .char_xfer (char_xfer),
        .en_cmd    (en_cmd),
        .dis_cmd   (dis_cmd),
        .at_one    (at_one),
        .load      (load),
        .dec       (dec),
        .rdy       (rdy)
    );

    rxto_count #(.BYTE_W(BYTE_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .preset_hi (preset_hi),
        .preset_lo (preset_lo),
        .load      (load),
        .dec       (dec),
        .at_one    (at_one)
    );

    // Gate the ready flag with the mask to form the interrupt.
    always_comb begin
        irq = rdy && irq_mask;
    end

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mask |-> !irq);
    p_no_load_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && dec));
endmodule

// File: tb/rxto_timer_test.sv
module rxto_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       char_xfer = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [7:0] preset_hi = 8'h00;
    logic [7:0] preset_lo = 8'h00;
    logic       irq_mask = 1'b0;
    logic       rdy;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    int gap = 1;
    int tick_ctr = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    bit    m_mode = 0;
    int    m_phase = 0;  // 0 park, 1 halt, 2 load, 3 run
    int    m_cnt = 0;
    bit    m_rdy = 0;
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    rxto_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .char_xfer(char_xfer),
        .cmd_wr(cmd_wr), .cmd_byte(cmd_byte), .preset_hi(preset_hi),
        .preset_lo(preset_lo), .irq_mask(irq_mask), .rdy(rdy), .irq(irq)
    );

    // Behavioural model, following the requirement priorities (R10).
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_mode = 0; m_phase = 0; m_cnt = 0; m_rdy = 0; m_tag = "R1";
        end else if (cmd_wr && cmd_byte[7:4] == 4'hA) begin
            m_mode = 1; m_phase = 0; m_rdy = 0; m_tag = "R4";
        end else if (cmd_wr && cmd_byte[7:4] == 4'hC) begin
            m_mode = 0; m_phase = 0; m_tag = "R5";
        end else if (char_xfer && m_mode) begin
            m_phase = 1; m_rdy = 0; m_tag = "R3";
        end else if (tick) begin
            if (m_phase == 1) begin
                m_cnt = ({preset_hi, preset_lo} == 16'h0) ? 65536 : int'({preset_hi, preset_lo});
                m_phase = 2;
            end else if (m_phase == 2) begin
                m_phase = 3;
            end else if (m_phase == 3) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_rdy = 1; m_phase = 0; m_tag = "R2";
                end
            end
        end
    end

    // Timer clock-enable generator.
    always @(negedge clk) begin
        tick_ctr++;
        tick <= (tick_ctr % gap) == 0;
    end

    // Compare outputs with the model on every cycle.
    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if (rdy !== m_rdy) begin
                n_bad++;
                $display("FAIL %s rdy actual=%0b expected=%0b t=%0t", m_tag, rdy, m_rdy, $time);
            end
            n_cmp++;
            if (irq !== (m_rdy && irq_mask)) begin
                n_bad++;
                $display("FAIL R7 irq actual=%0b expected=%0b t=%0t", irq, m_rdy && irq_mask, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rdy(input bit exp, input string req);
        n_cmp++;
        if (rdy !== exp) begin
            n_bad++;
            $display("FAIL %s direct rdy actual=%0b expected=%0b t=%0t", req, rdy, exp, $time);
        end
    endtask

    task automatic cmd(input logic [7:0] b);
        cmd_byte = b; cmd_wr = 1'b1; step(1); cmd_wr = 1'b0;
    endtask

    task automatic chr();
        char_xfer = 1'b1; step(1); char_xfer = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 190000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        step(4);
        expect_rdy(1'b0, "R1");
        rst_n = 1'b1;
        step(2);
        expect_rdy(1'b0, "R1");

        // R6: mode off, characters ignored
        gap = 1; preset_hi = 8'h00; preset_lo = 8'h03;
        chr(); step(10); chr(); step(10);
        expect_rdy(1'b0, "R6");

        // R2: exact expiry tick, preset 5, tick every cycle
        irq_mask = 1'b1;
        cmd(8'hA0);
        preset_lo = 8'h05;
        chr();
        step(6); expect_rdy(1'b0, "R2");
        step(1); expect_rdy(1'b1, "R2");
        step(3);
        // R3: character withdraws the flag on the next edge
        chr(); expect_rdy(1'b0, "R3");
        step(12); expect_rdy(1'b1, "R3");
        irq_mask = 1'b0; step(2);
        irq_mask = 1'b1; step(2);

        // R3: retrigger keeps postponing expiry (ticks every 3 cycles)
        gap = 3; preset_lo = 8'd20;
        for (int i = 0; i < 8; i++) begin chr(); step(30); end
        expect_rdy(1'b0, "R3");
        step(100); expect_rdy(1'b1, "R3");

        // R5: disable keeps the flag, then stops counting
        cmd(8'hC3); step(5); expect_rdy(1'b1, "R5");
        chr(); step(3); expect_rdy(1'b1, "R6");
        cmd(8'hA5); step(1); expect_rdy(1'b0, "R4");
        chr(); step(10); cmd(8'hC0); step(200); expect_rdy(1'b0, "R5");

        // R4: enable parks the counter until data arrives
        cmd(8'hAF); step(300); expect_rdy(1'b0, "R4");

        // R9: other nibbles do nothing
        gap = 1; preset_lo = 8'd4;
        chr(); cmd(8'h5A); cmd(8'hB0); cmd(8'h0C); step(10);
        expect_rdy(1'b1, "R9");
        cmd(8'hFF); cmd(8'h1A); expect_rdy(1'b1, "R9");

        // R10: enable and character in the same cycle, enable wins
        cmd_byte = 8'hA0; cmd_wr = 1'b1; char_xfer = 1'b1; step(1);
        cmd_wr = 1'b0; char_xfer = 1'b0;
        step(20); expect_rdy(1'b0, "R10");
        // R10: character beats a tick in the same cycle
        chr(); step(6); expect_rdy(1'b1, "R10");

        // R8: zero preset counts the full range
        preset_hi = 8'h00; preset_lo = 8'h00;
        chr();
        step(65537); expect_rdy(1'b0, "R8");
        step(1); expect_rdy(1'b1, "R8");
        step(4);
        finish_run();
    end
endmodule